// File: doc/BRIEF.md
# Dual-Port MAC Interrupt Aggregator

This block gathers interrupt events from a two-port Ethernet MAC that can relay frames from one port to the other. It drives three CPU interrupt lines: one for port 0 transmit/receive events, one for port 1 transmit/receive events, and one for relay transfers between the ports. Each line has a sticky status register and an enable register. Software reaches all of them over a single-cycle register bus. Each port also has a secondary MAC-status register with its own enable register. The secondary pair feeds one summary bit in that port's main status register.

A chosen subset of port events is held back until the descriptor write-back for that port has completed. Each port has a small deferral state machine with two states. In `DF_IDLE` nothing is waiting. An event on a held-back bit in a cycle without a write-back pulse moves it to `DF_HOLD`. In `DF_HOLD` at least one held-back event is stored in a pending flag, and further events merge into that flag. The write-back-done pulse moves the machine back to `DF_IDLE` and hands all pending bits to status. The cycle `DF_IDLE` to `DF_HOLD` to `DF_IDLE` is the only path.

Register word addresses (`reg_addr`):

| Address | Register |
|---|---|
| 0 | port 0 status |
| 1 | port 0 enable |
| 2 | port 1 status |
| 3 | port 1 enable |
| 4 | port 0 MAC status |
| 5 | port 0 MAC enable |
| 6 | port 1 MAC status |
| 7 | port 1 MAC enable |
| 8 | relay status |
| 9 | relay enable |

Port status and enable registers have 9 bits:
- Bits 7:0 hold the port events.
- Bit 8 is the MAC summary.
- Bits 3:0 are the held-back events.

MAC status, MAC enable, relay status and relay enable registers have 4 bits each.

Top module: `mac_irq_hub`

## Requirements
- R1: After reset, every status, pending and enable bit is 0. All three interrupt outputs are 0, and every register reads 0.
- R2: An event on a port bit in 7:4, a MAC bit or a relay bit sets its status bit at the next clock edge. The bit stays set until it is cleared.
- R3: Writing a status register clears exactly the bits written as 1, at that clock edge. Bits written as 0 keep their value.
- R4: If an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: An event on port bits 3:0 does not show in status. It is held until the port's write-back-done pulse. At that edge every held event, including repeated events merged together, is set in status, and the pending flags clear.
- R6: Port status bit 8 reads as the OR of (MAC status AND MAC enable) for that port. Writing 1 to bit 8 has no effect. The bit clears only when the MAC status bits behind it are cleared or disabled.
- R7: Each interrupt output equals the OR of (status AND enable) of its register in the previous cycle. The output is 0 while that enable register is 0.
- R8: The three outputs are independent: `irq_p0` follows port 0, `irq_p1` follows port 1, and `irq_fwd` follows the relay registers.
- R9: An enable register reads back the written value, masked to its width. Bits above a register's width, and addresses 10 to 15, read 0. Writes to addresses 10 to 15 change nothing.
- R10: A held-back event that arrives in the same cycle as the write-back-done pulse is set in status at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_ev | input | 8 | Port 0 event pulses |
| p0_wb_done | input | 1 | Port 0 descriptor write-back complete pulse |
| p1_ev | input | 8 | Port 1 event pulses |
| p1_wb_done | input | 1 | Port 1 descriptor write-back complete pulse |
| p0_mac_ev | input | 4 | Port 0 MAC status event pulses |
| p1_mac_ev | input | 4 | Port 1 MAC status event pulses |
| fwd_ev | input | 4 | Relay transfer event pulses |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| irq_p0 | output | 1 | Port 0 interrupt line |
| irq_p1 | output | 1 | Port 1 interrupt line |
| irq_fwd | output | 1 | Relay interrupt line |

## Verification
Two pairs of functions can fall in the same cycle:
- An event and a software write-1 clear on the same status bit.
- A fresh held-back event and the write-back-done pulse that flushes the pending flags.

Directed steps provoke both collisions on chosen bits, and the result is read back and compared with literal values. A random phase then drives dense events, pulses and writes so that both collisions recur many times. Every cycle is compared against a bench model written from R3, R4, R5 and R10.

// File: rtl/mac_irq_pkg.sv
`timescale 1ns/100ps
package mac_irq_pkg;

    // Register word offsets; ports are laid out with a fixed stride
    localparam int OFS_PSTAT    = 0;
    localparam int OFS_PEN      = 1;
    localparam int OFS_MSTAT    = 4;
    localparam int OFS_MEN      = 5;
    localparam int PORT_STRIDE  = 2;
    localparam int OFS_FSTAT    = 8;
    localparam int OFS_FEN      = 9;
    localparam int NUM_PORTS    = 2;

    typedef enum logic {
        DF_IDLE = 1'b0,
        DF_HOLD = 1'b1
    } defer_state_e;

endpackage

// File: rtl/irq_sticky_bank.sv
`timescale 1ns/100ps
module irq_sticky_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] status
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_v) | set_v;
        end
    end

    // R2: a set bit that is not cleared stays set
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status) & ~$past(clr_v)) == ($past(status) & ~$past(clr_v))));

    // R3: a cleared bit without a concurrent set goes to 0
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr_v) & ~$past(set_v)) == '0));

    // R4: a set is never lost to a concurrent clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(set_v)) == $past(set_v)));

endmodule

// File: rtl/irq_defer_fsm.sv
`timescale 1ns/100ps
module irq_defer_fsm import mac_irq_pkg::*; #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         wb_done,
    output logic [W-1:0] post
);

    defer_state_e state_q, state_d;
    logic [W-1:0] pend_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DF_IDLE: if ((|ev) && !wb_done) state_d = DF_HOLD;
            DF_HOLD: if (wb_done)           state_d = DF_IDLE;
            default: state_d = DF_IDLE;
        endcase
    end

    // Pending flags: merge while waiting, flush on the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wb_done) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q | ev;
        end
    end

    // Outputs
    always_comb begin
        post = '0;
        unique case (state_q)
            DF_IDLE: if (wb_done) post = ev;
            DF_HOLD: if (wb_done) post = pend_q | ev;
            default: post = '0;
        endcase
    end

    // R5: nothing is pending while idle
    p_idle_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DF_IDLE) |-> (pend_q == '0));

    // R5: the pulse empties the pending flags and returns to idle
    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |=> ((pend_q == '0) && (state_q == DF_IDLE)));

endmodule

// File: rtl/irq_port_unit.sv
`timescale 1ns/100ps
module irq_port_unit #(
    parameter int          EV_W       = 8,
    parameter int          MEV_W      = 4,
    parameter logic [31:0] DEFER_MASK = 32'h0000_000F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  ev,
    input  logic             wb_done,
    input  logic [MEV_W-1:0] mac_ev,
    input  logic [EV_W-1:0]  clr_main,
    input  logic [MEV_W-1:0] clr_mac,
    input  logic [MEV_W-1:0] mac_en,
    output logic [EV_W:0]    stat_rd,
    output logic [MEV_W-1:0] mac_stat
);

    localparam logic [EV_W-1:0] DMASK = DEFER_MASK[EV_W-1:0];

    logic [EV_W-1:0] ev_now, ev_held, ev_post, main_set, main_stat;
    logic            summary;

    assign ev_now   = ev & ~DMASK;
    assign ev_held  = ev & DMASK;
    assign main_set = ev_now | ev_post;

    irq_defer_fsm #(.W(EV_W)) u_defer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev_held),
        .wb_done (wb_done),
        .post    (ev_post)
    );

    irq_sticky_bank #(.W(EV_W)) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (main_set),
        .clr_v  (clr_main),
        .status (main_stat)
    );

    irq_sticky_bank #(.W(MEV_W)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (mac_ev),
        .clr_v  (clr_mac),
        .status (mac_stat)
    );

    assign summary = |(mac_stat & mac_en);
    assign stat_rd = {summary, main_stat};

    // R6: summary is low whenever the secondary status is empty
    p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_stat == '0) |-> (stat_rd[EV_W] == 1'b0));

endmodule

// File: rtl/mac_irq_hub.sv
`timescale 1ns/100ps
module mac_irq_hub import mac_irq_pkg::*; #(
    parameter int          PEV_W      = 8,
    parameter int          MEV_W      = 4,
    parameter int          FEV_W      = 4,
    parameter int          ADDR_W     = 4,
    parameter logic [31:0] DEFER_MASK = 32'h0000_000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEV_W-1:0]  p0_ev,
    input  logic              p0_wb_done,
    input  logic [PEV_W-1:0]  p1_ev,
    input  logic              p1_wb_done,
    input  logic [MEV_W-1:0]  p0_mac_ev,
    input  logic [MEV_W-1:0]  p1_mac_ev,
    input  logic [FEV_W-1:0]  fwd_ev,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_p0,
    output logic              irq_p1,
    output logic              irq_fwd
);

    localparam int PST_W = PEV_W + 1;

    logic [NUM_PORTS-1:0][PEV_W-1:0] ev_a;
    logic [NUM_PORTS-1:0]            wb_a;
    logic [NUM_PORTS-1:0][MEV_W-1:0] mev_a;
    logic [NUM_PORTS-1:0][PST_W-1:0] p_stat, p_en_q;
    logic [NUM_PORTS-1:0][MEV_W-1:0] m_stat, m_en_q;
    logic [NUM_PORTS-1:0][PEV_W-1:0] p_clr;
    logic [NUM_PORTS-1:0][MEV_W-1:0] m_clr;
    logic [FEV_W-1:0]                f_stat, f_en_q, f_clr;
    logic [2:0]                      irq_q;
    logic                            unused_wdata;

    assign ev_a  = {p1_ev, p0_ev};
    assign wb_a  = {p1_wb_done, p0_wb_done};
    assign mev_a = {p1_mac_ev, p0_mac_ev};
    assign unused_wdata = ^reg_wdata;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFS_PSTAT + PORT_STRIDE * p);
            localparam logic [ADDR_W-1:0] A_MS = ADDR_W'(OFS_MSTAT + PORT_STRIDE * p);

            assign p_clr[p] = (reg_we && (reg_addr == A_ST)) ? reg_wdata[PEV_W-1:0] : '0;
            assign m_clr[p] = (reg_we && (reg_addr == A_MS)) ? reg_wdata[MEV_W-1:0] : '0;

            irq_port_unit #(
                .EV_W       (PEV_W),
                .MEV_W      (MEV_W),
                .DEFER_MASK (DEFER_MASK)
            ) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .ev       (ev_a[p]),
                .wb_done  (wb_a[p]),
                .mac_ev   (mev_a[p]),
                .clr_main (p_clr[p]),
                .clr_mac  (m_clr[p]),
                .mac_en   (m_en_q[p]),
                .stat_rd  (p_stat[p]),
                .mac_stat (m_stat[p])
            );

            // R7: a line stays low after a cycle with its enable register empty
            p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(p_en_q[p]) == '0) |-> (irq_q[p] == 1'b0));
        end
    endgenerate

    assign f_clr = (reg_we && (reg_addr == ADDR_W'(OFS_FSTAT))) ? reg_wdata[FEV_W-1:0] : '0;

    irq_sticky_bank #(.W(FEV_W)) u_fwd (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (fwd_ev),
        .clr_v  (f_clr),
        .status (f_stat)
    );

    // Enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_en_q <= '0;
            m_en_q <= '0;
            f_en_q <= '0;
        end else if (reg_we) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (reg_addr == ADDR_W'(OFS_PEN + PORT_STRIDE * p)) p_en_q[p] <= reg_wdata[PST_W-1:0];
                if (reg_addr == ADDR_W'(OFS_MEN + PORT_STRIDE * p)) m_en_q[p] <= reg_wdata[MEV_W-1:0];
            end
            if (reg_addr == ADDR_W'(OFS_FEN)) f_en_q <= reg_wdata[FEV_W-1:0];
        end
    end

    // Registered interrupt lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q[0] <= |(p_stat[0] & p_en_q[0]);
            irq_q[1] <= |(p_stat[1] & p_en_q[1]);
            irq_q[2] <= |(f_stat & f_en_q);
        end
    end

    assign irq_p0  = irq_q[0];
    assign irq_p1  = irq_q[1];
    assign irq_fwd = irq_q[2];

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_addr == ADDR_W'(OFS_PSTAT + PORT_STRIDE * p)) reg_rdata[PST_W-1:0] = p_stat[p];
            if (reg_addr == ADDR_W'(OFS_PEN   + PORT_STRIDE * p)) reg_rdata[PST_W-1:0] = p_en_q[p];
            if (reg_addr == ADDR_W'(OFS_MSTAT + PORT_STRIDE * p)) reg_rdata[MEV_W-1:0] = m_stat[p];
            if (reg_addr == ADDR_W'(OFS_MEN   + PORT_STRIDE * p)) reg_rdata[MEV_W-1:0] = m_en_q[p];
        end
        if (reg_addr == ADDR_W'(OFS_FSTAT)) reg_rdata[FEV_W-1:0] = f_stat;
        if (reg_addr == ADDR_W'(OFS_FEN))   reg_rdata[FEV_W-1:0] = f_en_q;
    end

    // R9: unmapped addresses read 0
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(OFS_FEN)) |-> (reg_rdata == '0));

    // R8: relay line stays low after a cycle with the relay enable empty
    p_fwd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(f_en_q) == '0) |-> (irq_fwd == 1'b0));

endmodule

// File: tb/mac_irq_hub_test.sv
`timescale 1ns/100ps
module mac_irq_hub_test;

    localparam logic [7:0] DEF = 8'h0F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  p0_ev, p1_ev;
    logic        p0_wb, p1_wb;
    logic [3:0]  p0_mev, p1_mev, fwd_ev;
    logic [3:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq0, irq1, irqf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_st [2];
    logic [7:0] m_pd [2];
    logic [8:0] m_en [2];
    logic [3:0] m_ms [2];
    logic [3:0] m_me [2];
    logic [3:0] m_fs, m_fe;
    logic [2:0] m_irq;

    always #2 clk = ~clk;

    mac_irq_hub uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .p0_ev      (p0_ev),
        .p0_wb_done (p0_wb),
        .p1_ev      (p1_ev),
        .p1_wb_done (p1_wb),
        .p0_mac_ev  (p0_mev),
        .p1_mac_ev  (p1_mev),
        .fwd_ev     (fwd_ev),
        .reg_addr   (addr),
        .reg_we     (we),
        .reg_wdata  (wdata),
        .reg_rdata  (rdata),
        .irq_p0     (irq0),
        .irq_p1     (irq1),
        .irq_fwd    (irqf)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] mdl_read(input logic [3:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            4'd0: r[8:0] = {|(m_ms[0] & m_me[0]), m_st[0]};
            4'd1: r[8:0] = m_en[0];
            4'd2: r[8:0] = {|(m_ms[1] & m_me[1]), m_st[1]};
            4'd3: r[8:0] = m_en[1];
            4'd4: r[3:0] = m_ms[0];
            4'd5: r[3:0] = m_me[0];
            4'd6: r[3:0] = m_ms[1];
            4'd7: r[3:0] = m_me[1];
            4'd8: r[3:0] = m_fs;
            4'd9: r[3:0] = m_fe;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd2: return "R2";
            4'd4, 4'd6: return "R6";
            4'd8:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 2; p++) begin
            m_st[p] = '0; m_pd[p] = '0; m_en[p] = '0; m_ms[p] = '0; m_me[p] = '0;
        end
        m_fs = '0; m_fe = '0; m_irq = '0;
    endtask

    task automatic model_step();
        logic [2:0] irq_n;
        logic [7:0] evs [2];
        logic       wbs [2];
        logic [3:0] mevs [2];
        logic [7:0] clr, imm, dv;
        logic [3:0] mclr;
        logic [8:0] full;
        evs[0] = p0_ev; evs[1] = p1_ev;
        wbs[0] = p0_wb; wbs[1] = p1_wb;
        mevs[0] = p0_mev; mevs[1] = p1_mev;
        for (int p = 0; p < 2; p++) begin
            full = {|(m_ms[p] & m_me[p]), m_st[p]};
            irq_n[p] = |(full & m_en[p]);
        end
        irq_n[2] = |(m_fs & m_fe);
        for (int p = 0; p < 2; p++) begin
            clr  = (we && addr == 4'(2 * p)) ? wdata[7:0] : 8'h00;
            mclr = (we && addr == 4'(4 + 2 * p)) ? wdata[3:0] : 4'h0;
            imm  = evs[p] & ~DEF;
            dv   = evs[p] & DEF;
            if (wbs[p]) begin
                m_st[p] = (m_st[p] & ~clr) | imm | m_pd[p] | dv;
                m_pd[p] = '0;
            end else begin
                m_st[p] = (m_st[p] & ~clr) | imm;
                m_pd[p] = m_pd[p] | dv;
            end
            m_ms[p] = (m_ms[p] & ~mclr) | mevs[p];
            if (we && addr == 4'(1 + 2 * p)) m_en[p] = wdata[8:0];
            if (we && addr == 4'(5 + 2 * p)) m_me[p] = wdata[3:0];
        end
        m_fs = (m_fs & ~((we && addr == 4'd8) ? wdata[3:0] : 4'h0)) | fwd_ev;
        if (we && addr == 4'd9) m_fe = wdata[3:0];
        m_irq = irq_n;
    endtask

    task automatic clear_in();
        p0_ev = '0; p1_ev = '0; p0_wb = 1'b0; p1_wb = 1'b0;
        p0_mev = '0; p1_mev = '0; fwd_ev = '0;
        addr = '0; we = 1'b0; wdata = '0;
    endtask

    // One cycle: inputs already set at the negedge
    task automatic tick();
        #0.5;
        check(tag_of(addr), rdata, mdl_read(addr));
        check("R7", {31'd0, irq0}, {31'd0, m_irq[0]});
        check("R7", {31'd0, irq1}, {31'd0, m_irq[1]});
        check("R8", {31'd0, irqf}, {31'd0, m_irq[2]});
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        clear_in(); addr = a; we = 1'b1; wdata = d; tick();
    endtask

    task automatic read_exp(input logic [3:0] a, input logic [31:0] exp, input string req);
        clear_in(); addr = a;
        #0.2;
        check(req, rdata, exp);
        tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 1'b0;
        model_reset();
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        #0.2;
        check("R1", {29'd0, irq0, irq1, irqf}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads 0 after reset
        for (int a = 0; a < 10; a++) read_exp(4'(a), 32'd0, "R1");

        // R2 / R5: bit4 immediate, bit0 held back
        clear_in(); p0_ev = 8'h11; tick();
        read_exp(4'd0, 32'h10, "R2");
        clear_in(); p0_ev = 8'h04; tick();
        read_exp(4'd0, 32'h10, "R5");
        // R10: held event in the same cycle as the pulse
        clear_in(); p0_ev = 8'h02; p0_wb = 1'b1; tick();
        read_exp(4'd0, 32'h17, "R10");
        clear_in(); p0_wb = 1'b1; tick();
        read_exp(4'd0, 32'h17, "R5");

        // R3: write 0 no effect, write 1 clears
        wr(4'd0, 32'h0);
        read_exp(4'd0, 32'h17, "R3");
        wr(4'd0, 32'h1);
        read_exp(4'd0, 32'h16, "R3");

        // R4: set beats clear
        clear_in(); p0_ev = 8'h20; addr = 4'd0; we = 1'b1; wdata = 32'h20; tick();
        read_exp(4'd0, 32'h36, "R4");

        // R7: one-cycle lag after enabling
        wr(4'd1, 32'h10);
        #0.2; check("R7", {31'd0, irq0}, 32'd0);
        clear_in(); tick();
        #0.2; check("R7", {31'd0, irq0}, 32'd1);
        check("R8", {30'd0, irq1, irqf}, 32'd0);

        // R6: summary bit behaviour
        clear_in(); p0_mev = 4'h4; tick();
        read_exp(4'd4, 32'h4, "R6");
        read_exp(4'd0, 32'h36, "R6");
        wr(4'd5, 32'h4);
        read_exp(4'd0, 32'h136, "R6");
        wr(4'd0, 32'h100);
        read_exp(4'd0, 32'h136, "R6");
        wr(4'd4, 32'h4);
        read_exp(4'd4, 32'h0, "R6");
        read_exp(4'd0, 32'h36, "R6");

        // R9: width masking and unmapped addresses
        wr(4'd1, 32'hFFFF_FFFF);
        read_exp(4'd1, 32'h1FF, "R9");
        read_exp(4'd12, 32'h0, "R9");
        wr(4'd12, 32'hFFFF_FFFF);
        read_exp(4'd12, 32'h0, "R9");
        read_exp(4'd3, 32'h0, "R9");
        wr(4'd1, 32'h10);

        // R8: relay line independent of ports
        clear_in(); fwd_ev = 4'h8; tick();
        wr(4'd9, 32'h8);
        #0.2; check("R8", {31'd0, irqf}, 32'd0);
        clear_in(); tick();
        #0.2; check("R8", {31'd0, irqf}, 32'd1);
        check("R8", {31'd0, irq1}, 32'd0);

        // Random phase: collisions of events, pulses and clears
        for (int i = 0; i < 4000; i++) begin
            clear_in();
            if ($urandom % 3 == 0) p0_ev  = 8'($urandom);
            if ($urandom % 3 == 0) p1_ev  = 8'($urandom);
            if ($urandom % 5 == 0) p0_wb  = 1'b1;
            if ($urandom % 5 == 0) p1_wb  = 1'b1;
            if ($urandom % 4 == 0) p0_mev = 4'($urandom);
            if ($urandom % 4 == 0) p1_mev = 4'($urandom);
            if ($urandom % 4 == 0) fwd_ev = 4'($urandom);
            addr  = 4'($urandom % 12);
            we    = ($urandom % 3 == 0);
            wdata = $urandom;
            tick();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule